// File: doc/BRIEF.md
# Operand Effective Address Generator

This block takes a 6-bit operand specifier, a byte/word flag, the current values of the eight general registers and one extension word from the instruction stream. From these it works out where one instruction operand lives. The specifier holds a register number and an addressing mode. The result is one of two things: a flag saying the operand is the register itself, or a memory address. In the deferred modes, that address comes from a pointer the block first reads from memory through a small request/valid handshake.

Alongside the address, the block reports three things. It says whether an extension word was consumed. It gives the updated register value and a one-cycle write enable for the auto-increment and auto-decrement modes. It flags a word operand that falls on an odd address.

The step used by auto-increment and auto-decrement is not fixed. It depends on three things together: the operand size, whether the mode is deferred, and whether the register is the stack pointer (R6) or the program counter (R7). The instruction sequencer pulses `start` once per operand. It reads the result in the cycle `ea_valid` is high.

Top module: `opnd_ea_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no `start`, `ea_valid`, `wb_en` and `ptr_req` are low.
- R2: `spec` is `{mode[2:0], reg[2:0]}`. `start` is taken while the block is idle. For a non-deferred mode (0, 1, 2, 4, 6), `ea_valid` goes high for exactly one cycle, in the cycle after the clock edge that follows the capturing edge. Mode 0 reports `reg_direct`=1.
- R3: Mode 1 gives the selected register value as the address and requests no write-back.
- R4: Mode 2 gives the register value as the address and writes back register+step. Mode 3 reads the pointer at the register value and writes back register+2.
- R5: Mode 4 gives register-step as the address and writes it back. Mode 5 reads the pointer at register-2 and writes that value back.
- R6: The step is 1 only for a byte operation (`byte_op`=1) in mode 2 or 4 on R0 to R5. In every other case it is 2.
- R7: Modes 6 and 7 form register+`ext_word` for R0 to R6. For R7 they form `ext_word`+R7+2, where R7 holds the address of the extension word. Neither mode writes back.
- R8: Modes 3, 5 and 7 set `indirect`. They hold `ptr_req` high with a stable `ptr_addr` until `ptr_valid` is sampled. `ea_addr` then equals the `ptr_data` word, and `ea_valid` follows in the next cycle.
- R9: `ext_used` is 1 for modes 6 and 7 on any register, and for modes 2 and 3 on R7. Otherwise it is 0.
- R10: A word operation (`byte_op`=0) in a mode other than 0 whose final address has bit 0 set raises `odd_err`, and `wb_en` stays low.
- R11: `wb_en` is high only together with `ea_valid`, only for modes 2 to 5. `wb_sel` names the specifier's register and `wb_data` carries the new value.
- R12: A `start` seen while an operand is still in progress is ignored. The result of the pending operand is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin one operand; spec, byte_op, reg_file, ext_word captured |
| spec | input | 6 | Operand specifier {mode, register} |
| byte_op | input | 1 | 1 = byte operand, 0 = word operand |
| reg_file | input | 128 | Register values, R(i) at bits [16i+15:16i] |
| ext_word | input | 16 | Extension word following the instruction |
| ptr_req | output | 1 | Pointer read request |
| ptr_addr | output | 16 | Address of the pointer word to read |
| ptr_data | input | 16 | Pointer word returned by memory |
| ptr_valid | input | 1 | ptr_data is valid this cycle |
| ea_valid | output | 1 | One-cycle strobe: result outputs valid |
| ea_addr | output | 16 | Operand address (0 when reg_direct) |
| reg_direct | output | 1 | Operand is the register itself |
| indirect | output | 1 | A pointer fetch was performed |
| ext_used | output | 1 | The extension word was consumed |
| odd_err | output | 1 | Word operand on an odd address |
| wb_en | output | 1 | Register write-back enable, one cycle |
| wb_sel | output | 3 | Register to write back |
| wb_data | output | 16 | Updated register value |

## Verification
The assertions rely on memory behaving well. `ptr_valid` must arrive only while `ptr_req` is high, and `ptr_data` must be meaningful only in that cycle. The checker does not model what happens if memory strobes `ptr_valid` with no request outstanding. The stimulus respects this. It raises `ptr_valid` for a single cycle after a chosen wait of zero to two cycles, and only while `ptr_req` is seen high. It also changes `reg_file` and `ext_word` right after `start`, so any dependence on uncaptured inputs shows up as a wrong result. Every one of the 64 specifiers is swept under both operand sizes and four register sets, including values that wrap at zero and at the top of the range.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    M_REG     = 3'd0,
    M_REGDEF  = 3'd1,
    M_AINC    = 3'd2,
    M_AINCDEF = 3'd3,
    M_ADEC    = 3'd4,
    M_ADECDEF = 3'd5,
    M_IDX     = 3'd6,
    M_IDXDEF  = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_PTR  = 2'd2
  } state_e;

  // modes whose register points at a word-sized pointer
  function automatic logic mode_steps_pointer(mode_e m);
    return (m == M_AINCDEF) || (m == M_ADECDEF);
  endfunction

  function automatic logic mode_needs_fetch(mode_e m);
    return (m == M_AINCDEF) || (m == M_ADECDEF) || (m == M_IDXDEF);
  endfunction

endpackage

// File: rtl/eag_step.sv
module eag_step #(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7
) (
  input  eag_pkg::mode_e  mode,
  input  logic [RW-1:0]   rn,
  input  logic            byte_op,
  output logic [DW-1:0]   step
);
  import eag_pkg::*;

  logic narrow;

  always_comb begin
    narrow = byte_op
          && !mode_steps_pointer(mode)
          && (rn != RW'(SP_IDX))
          && (rn != RW'(PC_IDX));
    step   = narrow ? DW'(1) : DW'(2);
  end

endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc #(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7
) (
  input  eag_pkg::mode_e  mode,
  input  logic [RW-1:0]   rn,
  input  logic            byte_op,
  input  logic [DW-1:0]   rval,
  input  logic [DW-1:0]   ext,
  output logic            direct,
  output logic [DW-1:0]   addr,
  output logic            indirect,
  output logic            ext_used,
  output logic            wb_req,
  output logic [DW-1:0]   wb_val
);
  import eag_pkg::*;

  logic [DW-1:0] step;
  logic [DW-1:0] inc_val;
  logic [DW-1:0] dec_val;
  logic [DW-1:0] idx_base;
  logic [DW-1:0] idx_sum;
  logic          is_pc;

  eag_step #(
    .DW(DW), .RW(RW), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)
  ) step_i (
    .mode    (mode),
    .rn      (rn),
    .byte_op (byte_op),
    .step    (step)
  );

  always_comb begin
    is_pc    = (rn == RW'(PC_IDX));
    inc_val  = rval + step;
    dec_val  = rval - step;
    // program counter has already moved past the extension word
    idx_base = is_pc ? (rval + DW'(2)) : rval;
    idx_sum  = idx_base + ext;

    direct   = 1'b0;
    addr     = rval;
    wb_req   = 1'b0;
    wb_val   = rval;

    case (mode)
      M_REG: begin
        direct = 1'b1;
        addr   = '0;
      end
      M_REGDEF: begin
        addr = rval;
      end
      M_AINC, M_AINCDEF: begin
        addr   = rval;
        wb_req = 1'b1;
        wb_val = inc_val;
      end
      M_ADEC, M_ADECDEF: begin
        addr   = dec_val;
        wb_req = 1'b1;
        wb_val = dec_val;
      end
      M_IDX, M_IDXDEF: begin
        addr = idx_sum;
      end
      default: begin
        addr = rval;
      end
    endcase

    indirect = mode_needs_fetch(mode);
    ext_used = (mode == M_IDX) || (mode == M_IDXDEF)
            || (is_pc && ((mode == M_AINC) || (mode == M_AINCDEF)));
  end

endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic indirect,
  input  logic ptr_valid,
  output logic capture_en,
  output logic load_calc,
  output logic load_ptr,
  output logic ptr_req
);
  import eag_pkg::*;

  state_e state_q;
  state_e state_d;

  always_comb begin
    state_d    = state_q;
    capture_en = (state_q == ST_IDLE) && start;
    load_calc  = (state_q == ST_CALC) && !indirect;
    load_ptr   = (state_q == ST_PTR) && ptr_valid;
    ptr_req    = (state_q == ST_PTR);
    case (state_q)
      ST_IDLE: if (start)     state_d = ST_CALC;
      ST_CALC: state_d = indirect ? ST_PTR : ST_IDLE;
      ST_PTR:  if (ptr_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen #(
  parameter int DW     = 16,
  parameter int NREG   = 8,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7,
  localparam int RW     = $clog2(NREG),
  localparam int SPEC_W = 3 + RW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SPEC_W-1:0]   spec,
  input  logic                byte_op,
  input  logic [NREG*DW-1:0]  reg_file,
  input  logic [DW-1:0]       ext_word,
  output logic                ptr_req,
  output logic [DW-1:0]       ptr_addr,
  input  logic [DW-1:0]       ptr_data,
  input  logic                ptr_valid,
  output logic                ea_valid,
  output logic [DW-1:0]       ea_addr,
  output logic                reg_direct,
  output logic                indirect,
  output logic                ext_used,
  output logic                odd_err,
  output logic                wb_en,
  output logic [RW-1:0]       wb_sel,
  output logic [DW-1:0]       wb_data
);
  import eag_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // register file view
  logic [DW-1:0] gpr [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign gpr[g] = reg_file[g*DW +: DW];
  end

  // control
  logic capture_en, load_calc, load_ptr;
  logic calc_indirect;

  eag_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .indirect   (calc_indirect),
    .ptr_valid  (ptr_valid),
    .capture_en (capture_en),
    .load_calc  (load_calc),
    .load_ptr   (load_ptr),
    .ptr_req    (ptr_req)
  );

  // captured operand context
  mode_e         cap_mode;
  logic [RW-1:0] cap_rn;
  logic          cap_byte;
  logic [DW-1:0] cap_rval;
  logic [DW-1:0] cap_ext;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cap_mode <= M_REG;
      cap_rn   <= '0;
      cap_byte <= 1'b0;
      cap_rval <= '0;
      cap_ext  <= '0;
    end else if (capture_en) begin
      cap_mode <= mode_e'(spec[SPEC_W-1:RW]);
      cap_rn   <= spec[RW-1:0];
      cap_byte <= byte_op;
      cap_rval <= gpr[spec[RW-1:0]];
      cap_ext  <= ext_word;
    end
  end

  // address arithmetic
  logic          calc_direct, calc_ext_used, calc_wb_req;
  logic [DW-1:0] calc_addr, calc_wb_val;

  eag_addr_calc #(
    .DW(DW), .RW(RW), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)
  ) calc_i (
    .mode     (cap_mode),
    .rn       (cap_rn),
    .byte_op  (cap_byte),
    .rval     (cap_rval),
    .ext      (cap_ext),
    .direct   (calc_direct),
    .addr     (calc_addr),
    .indirect (calc_indirect),
    .ext_used (calc_ext_used),
    .wb_req   (calc_wb_req),
    .wb_val   (calc_wb_val)
  );

  assign ptr_addr = calc_addr;

  // result stage: next-state logic
  logic          load_any;
  logic [DW-1:0] fin_addr;
  logic          fin_odd;

  always_comb begin
    load_any = load_calc || load_ptr;
    fin_addr = load_ptr ? ptr_data : calc_addr;
    fin_odd  = !cap_byte && !calc_direct && fin_addr[0];
  end

  // result stage: registers
  logic          valid_q, wb_en_q, direct_q, ind_q, ext_q, odd_q;
  logic [DW-1:0] addr_q, wbv_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q  <= 1'b0;
      wb_en_q  <= 1'b0;
      direct_q <= 1'b0;
      ind_q    <= 1'b0;
      ext_q    <= 1'b0;
      odd_q    <= 1'b0;
      addr_q   <= '0;
      wbv_q    <= '0;
    end else begin
      valid_q <= load_any;
      wb_en_q <= load_any && calc_wb_req && !fin_odd;
      if (load_any) begin
        direct_q <= calc_direct;
        ind_q    <= calc_indirect;
        ext_q    <= calc_ext_used;
        odd_q    <= fin_odd;
        addr_q   <= fin_addr;
        wbv_q    <= calc_wb_val;
      end
    end
  end

  assign ea_valid   = valid_q;
  assign ea_addr    = addr_q;
  assign reg_direct = direct_q;
  assign indirect   = ind_q;
  assign ext_used   = ext_q;
  assign odd_err    = odd_q;
  assign wb_en      = wb_en_q;
  assign wb_sel     = cap_rn;
  assign wb_data    = wbv_q;

endmodule

// File: rtl/opnd_ea_gen_chk.sv
module opnd_ea_gen_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ea_valid,
  input logic          ptr_req,
  input logic          ptr_valid,
  input logic          odd_err,
  input logic          reg_direct,
  input logic          wb_en,
  input logic [DW-1:0] ea_addr,
  input logic [DW-1:0] ptr_addr
);

  // R2: result strobe lasts a single cycle
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |=> !ea_valid);

  // R8: an outstanding pointer request holds its address
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_req && !ptr_valid) |=> (ptr_req && $stable(ptr_addr)));

  // R8: no request remains open while the result is presented
  p_no_req_at_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> !ptr_req);

  // R11: write-back only beside a clean memory-operand result
  p_wb_with_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (ea_valid && !odd_err && !reg_direct));

  // R10: an odd-address flag implies an odd memory address
  p_odd_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && odd_err) |-> (ea_addr[0] && !reg_direct));

endmodule

bind opnd_ea_gen opnd_ea_gen_chk #(.DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ea_valid   (ea_valid),
  .ptr_req    (ptr_req),
  .ptr_valid  (ptr_valid),
  .odd_err    (odd_err),
  .reg_direct (reg_direct),
  .wb_en      (wb_en),
  .ea_addr    (ea_addr),
  .ptr_addr   (ptr_addr)
);

// File: tb/opnd_ea_gen_tb_top.sv
`timescale 1ns/1ps
module opnd_ea_gen_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [5:0]   spec;
  logic         byte_op;
  logic [127:0] reg_file;
  logic [15:0]  ext_word;
  logic         ptr_req;
  logic [15:0]  ptr_addr;
  logic [15:0]  ptr_data;
  logic         ptr_valid;
  logic         ea_valid;
  logic [15:0]  ea_addr;
  logic         reg_direct;
  logic         indirect;
  logic         ext_used;
  logic         odd_err;
  logic         wb_en;
  logic [2:0]   wb_sel;
  logic [15:0]  wb_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  opnd_ea_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .byte_op(byte_op),
    .reg_file(reg_file), .ext_word(ext_word), .ptr_req(ptr_req),
    .ptr_addr(ptr_addr), .ptr_data(ptr_data), .ptr_valid(ptr_valid),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .reg_direct(reg_direct),
    .indirect(indirect), .ext_used(ext_used), .odd_err(odd_err),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [5:0] sp, input logic byt,
                        input logic [15:0] base, input int dly,
                        input logic intrude);
    logic [2:0]  m;
    logic [2:0]  rn;
    logic [15:0] rv, stp, ext, pdat, e_addr, e_ptr, e_wbv, idx;
    logic        e_dir, e_ind, e_ext, e_wb, e_odd;
    m   = sp[5:3];
    rn  = sp[2:0];
    ext = 16'h0100 + 16'(sp) * 16'd4;
    pdat = 16'h4000 + 16'(sp) * 16'd2 + {15'd0, base[0]};
    rv  = base + 16'(rn) * 16'h0102;
    // R6: narrow step only for byte, modes 2/4, R0..R5
    stp = (byt && (m == 3'd2 || m == 3'd4) && rn < 3'd6) ? 16'd1 : 16'd2;
    idx = ext + rv + ((rn == 3'd7) ? 16'd2 : 16'd0);
    e_dir = 1'b0; e_ind = 1'b0; e_wb = 1'b0;
    e_addr = 16'h0; e_ptr = 16'h0; e_wbv = 16'h0;
    case (m)
      3'd0: e_dir = 1'b1;
      3'd1: e_addr = rv;
      3'd2: begin e_addr = rv; e_wb = 1'b1; e_wbv = rv + stp; end
      3'd3: begin e_ind = 1'b1; e_ptr = rv; e_addr = pdat; e_wb = 1'b1; e_wbv = rv + 16'd2; end
      3'd4: begin e_addr = rv - stp; e_wb = 1'b1; e_wbv = rv - stp; end
      3'd5: begin e_ind = 1'b1; e_ptr = rv - 16'd2; e_addr = pdat; e_wb = 1'b1; e_wbv = rv - 16'd2; end
      3'd6: e_addr = idx;
      default: begin e_ind = 1'b1; e_ptr = idx; e_addr = pdat; end
    endcase
    e_ext = (m >= 3'd6) || (rn == 3'd7 && (m == 3'd2 || m == 3'd3));
    e_odd = !byt && !e_dir && e_addr[0];
    if (e_odd) e_wb = 1'b0;

    @(negedge clk);
    spec = sp; byte_op = byt; ext_word = ext;
    for (int i = 0; i < 8; i++) reg_file[i*16 +: 16] = base + 16'(i) * 16'h0102;
    start = 1'b1;
    @(negedge clk);
    // inputs change after capture; R12: optional second start while busy
    reg_file = ~reg_file; ext_word = ~ext_word;
    if (intrude) begin spec = ~sp; byte_op = ~byt; end
    else start = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (e_ind) begin
      chk("R8", "ptr_req", 32'(ptr_req), 32'd1);
      chk("R5", "ptr_addr", 32'(ptr_addr), 32'(e_ptr));
      chk("R8", "early ea_valid", 32'(ea_valid), 32'd0);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk("R8", "ptr_req held", 32'(ptr_req), 32'd1);
      end
      ptr_valid = 1'b1; ptr_data = pdat;
      @(negedge clk);
      ptr_valid = 1'b0; ptr_data = 16'hDEAD;
    end
    chk("R2", "ea_valid", 32'(ea_valid), 32'd1);
    chk("R2", "reg_direct", 32'(reg_direct), 32'(e_dir));
    chk("R8", "indirect", 32'(indirect), 32'(e_ind));
    chk("R9", "ext_used", 32'(ext_used), 32'(e_ext));
    chk("R10", "odd_err", 32'(odd_err), 32'(e_odd));
    chk("R11", "wb_en", 32'(wb_en), 32'(e_wb));
    if (!e_dir) chk(m >= 3'd6 ? "R7" : (m == 3'd4 ? "R5" : "R4"),
                    "ea_addr", 32'(ea_addr), 32'(e_addr));
    if (e_wb) begin
      chk("R11", "wb_sel", 32'(wb_sel), 32'(rn));
      chk("R4", "wb_data", 32'(wb_data), 32'(e_wbv));
    end
    if (m == 3'd1) chk("R3", "no wb", 32'(wb_en), 32'd0);
    if (intrude) chk("R12", "intruding start ignored", 32'(ea_addr), 32'(e_dir ? 16'h0 : e_addr));
    @(negedge clk);
    chk("R2", "ea_valid pulse end", 32'(ea_valid), 32'd0);
    chk("R11", "wb_en pulse end", 32'(wb_en), 32'd0);
    chk("R12", "no extra request", 32'(ptr_req), 32'd0);
  endtask

  initial begin
    logic [15:0] bases [4];
    bases[0] = 16'h1000; bases[1] = 16'h1001; bases[2] = 16'hFFFF; bases[3] = 16'h0000;
    rst_n = 1'b0; start = 1'b0; spec = '0; byte_op = 1'b0; reg_file = '0;
    ext_word = '0; ptr_data = '0; ptr_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "ea_valid in reset", 32'(ea_valid), 32'd0);
    chk("R1", "ptr_req in reset", 32'(ptr_req), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "ea_valid after reset", 32'(ea_valid), 32'd0);
    chk("R1", "wb_en after reset", 32'(wb_en), 32'd0);
    chk("R1", "ptr_req after reset", 32'(ptr_req), 32'd0);
    for (int b = 0; b < 4; b++)
      for (int y = 0; y < 2; y++)
        for (int s = 0; s < 64; s++)
          run_op(6'(s), y[0], bases[b], s % 3, (s % 5) == 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule